// File: doc/BRIEF.md
# Modem Line Status Register with Change Flags

This block is the modem-line status logic of one serial channel. It watches four active-low handshake pins: carrier detect, ring indicator, data-set-ready and clear-to-send. Each pin passes through a synchronizer. The block shows the lines as active-high levels in the upper nibble of an 8-bit status word. The lower nibble holds four sticky change flags. A CPU read strobe clears these flags.

When any flag is set and the interrupt enable is high, the block raises an interrupt request. In loopback mode the four status levels come from the channel's own modem-control outputs and the pins are ignored. A change in a looped control bit is flagged in the same way as a change on a pin.

The block also drives a transmit-hold output for hardware clear-to-send flow control. The hold output only changes between characters, so a character already on the line is always finished.

Top module: `mdm_status`

## Requirements
- R1: Outside loopback, rd_data[7], [6], [5] and [4] equal the complements of pin_cd_n, pin_ri_n, pin_dsr_n and pin_cts_n. A pin change reaches rd_data on the third rising clock edge after the change.
- R2: In loopback, rd_data[7:4] equals {mc_op2, mc_op1, mc_dtr, mc_rts} one clock edge after those bits change. The pins have no effect on rd_data.
- R3: rd_data[3] (carrier change flag) becomes 1 when status bit 7 changes in either direction.
- R4: rd_data[2] (ring flag) becomes 1 only when status bit 6 falls from 1 to 0, which is pin_ri_n rising from 0 to 1. A rise of status bit 6 leaves it 0.
- R5: rd_data[1] flags any change of status bit 5, and rd_data[0] flags any change of status bit 4.
- R6: The flags stay set until a cycle with rd_stb high. In that cycle rd_data still shows the flags. From the next edge they read 0.
- R7: If a change is detected on the same edge as a read, the flag for that change ends up set.
- R8: irq is 1 exactly when irq_en is 1 and at least one of rd_data[3:0] is 1.
- R9: In loopback, changes of the looped control bits set the change flags under the rules of R3 to R5.
- R10: While flow_en is 0, tx_hold is 0 from the next edge on.
- R11: While flow_en is 1 and tx_busy is 0, tx_hold becomes the complement of status bit 4 on the next edge. While tx_busy is 1, tx_hold keeps its value.
- R12: After reset, with all pins high, rd_data is 8'h00 and irq and tx_hold are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_cd_n | input | 1 | Carrier detect pin, active low |
| pin_ri_n | input | 1 | Ring indicator pin, active low |
| pin_dsr_n | input | 1 | Data-set-ready pin, active low |
| pin_cts_n | input | 1 | Clear-to-send pin, active low |
| loopback | input | 1 | Take status levels from control bits, not pins |
| mc_dtr | input | 1 | Modem-control DTR output bit |
| mc_rts | input | 1 | Modem-control RTS output bit |
| mc_op1 | input | 1 | Modem-control user output 1 |
| mc_op2 | input | 1 | Modem-control user output 2 |
| flow_en | input | 1 | Hardware clear-to-send flow control enable |
| tx_busy | input | 1 | Transmitter is sending a character |
| irq_en | input | 1 | Modem-status interrupt enable |
| rd_stb | input | 1 | CPU read of the status word |
| rd_data | output | 8 | Status levels [7:4] and change flags [3:0] |
| irq | output | 1 | Modem-status interrupt request |
| tx_hold | output | 1 | Stop starting new characters |

## Verification
Two functions can meet on one clock edge: a detected line change that sets a flag, and a CPU read that clears all flags. The bench times a clear-to-send pin change so that its third synchronizer edge falls in the cycle where rd_stb is high. It then checks two things: the read data in that cycle shows the earlier value, and the change flag is still set afterwards. A second meeting point is tx_busy against a clear-to-send change. The bench checks that tx_hold stays stable during the whole busy window and moves only one edge after busy drops.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int NLINES = 4;
    // Index of each line inside the 4-bit level and flag vectors
    localparam int L_CTS = 0;
    localparam int L_DSR = 1;
    localparam int L_RI  = 2;
    localparam int L_CD  = 3;
    // Lines whose flag only fires on a 1 -> 0 level transition
    localparam logic [NLINES-1:0] FALL_ONLY = NLINES'(1) << L_RI;

    typedef struct packed {
        logic [NLINES-1:0] level;
        logic [NLINES-1:0] delta;
    } mdm_state_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= RST_VAL;
            else        stg_q[g] <= stg_d[g];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
    parameter int           W         = 4,
    parameter logic [W-1:0] FALL_MASK = '0
) (
    input  logic [W-1:0] level_d,
    input  logic [W-1:0] level_q,
    output logic [W-1:0] set_vec
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        if (FALL_MASK[g]) begin : g_fall
            assign set_vec[g] = level_q[g] & ~level_d[g];
        end else begin : g_any
            assign set_vec[g] = level_q[g] ^ level_d[g];
        end
    end
endmodule

// File: rtl/mdm_flow.sv
module mdm_flow (
    input  logic clk,
    input  logic rst_n,
    input  logic flow_en,
    input  logic tx_busy,
    input  logic cts_level,
    output logic tx_hold
);
    logic hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (!flow_en)      hold_d = 1'b0;
        else if (!tx_busy) hold_d = ~cts_level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold_d;
    end

    assign tx_hold = hold_q;

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_en |=> !tx_hold); // R10
    AST_HOLD_BUSY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && tx_busy) |=> $stable(tx_hold)); // R11
endmodule

// File: rtl/mdm_status.sv
module mdm_status #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_cd_n,
    input  logic       pin_ri_n,
    input  logic       pin_dsr_n,
    input  logic       pin_cts_n,
    input  logic       loopback,
    input  logic       mc_dtr,
    input  logic       mc_rts,
    input  logic       mc_op1,
    input  logic       mc_op2,
    input  logic       flow_en,
    input  logic       tx_busy,
    input  logic       irq_en,
    input  logic       rd_stb,
    output logic [7:0] rd_data,
    output logic       irq,
    output logic       tx_hold
);
    import mdm_pkg::*;

    logic [NLINES-1:0] pin_raw, pin_sync, level_sel, set_vec;
    mdm_state_t st_d, st_q;

    assign pin_raw = {pin_cd_n, pin_ri_n, pin_dsr_n, pin_cts_n};

    mdm_sync #(.W(NLINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_raw), .dout(pin_sync)
    );

    assign level_sel = loopback ? {mc_op2, mc_op1, mc_dtr, mc_rts} : ~pin_sync;

    mdm_delta #(.W(NLINES), .FALL_MASK(FALL_ONLY)) u_delta (
        .level_d(level_sel), .level_q(st_q.level), .set_vec(set_vec)
    );

    always_comb begin
        st_d       = st_q;
        st_d.level = level_sel;
        st_d.delta = (rd_stb ? '0 : st_q.delta) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = {st_q.level, st_q.delta};
    assign irq     = irq_en & (|st_q.delta);

    mdm_flow u_flow (
        .clk(clk), .rst_n(rst_n), .flow_en(flow_en), .tx_busy(tx_busy),
        .cts_level(st_q.level[L_CTS]), .tx_hold(tx_hold)
    );

    AST_CD_EITHER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] != $past(rd_data[7])) |-> rd_data[3]); // R3
    AST_RI_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[2]) |-> ($past(rd_data[6]) && !rd_data[6])); // R4
    AST_DSR_CTS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[5:4] != $past(rd_data[5:4])) |->
        ((rd_data[5] == $past(rd_data[5]) || rd_data[1]) &&
         (rd_data[4] == $past(rd_data[4]) || rd_data[0]))); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && set_vec == '0) |=> rd_data[3:0] == '0); // R6
    AST_SET_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && set_vec != '0) |=> rd_data[3:0] != '0); // R7
    AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0 && irq_en) |=> (irq || !irq_en)); // R8
    AST_LOOP_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        loopback |=> rd_data[7:4] == $past({mc_op2, mc_op1, mc_dtr, mc_rts})); // R2
endmodule

// File: tb/tb_mdm_status.sv
module tb_mdm_status;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cd_n = 1'b1, ri_n = 1'b1, dsr_n = 1'b1, cts_n = 1'b1;
    logic loopback = 1'b0, dtr = 1'b0, rts = 1'b0, op1 = 1'b0, op2 = 1'b0;
    logic flow_en = 1'b0, tx_busy = 1'b0, irq_en = 1'b0, rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic irq, tx_hold;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        int         sig;   // 0 rd_data, 1 irq, 2 tx_hold
        logic [7:0] val;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mdm_status dut (
        .clk(clk), .rst_n(rst_n),
        .pin_cd_n(cd_n), .pin_ri_n(ri_n), .pin_dsr_n(dsr_n), .pin_cts_n(cts_n),
        .loopback(loopback), .mc_dtr(dtr), .mc_rts(rts), .mc_op1(op1), .mc_op2(op2),
        .flow_en(flow_en), .tx_busy(tx_busy), .irq_en(irq_en), .rd_stb(rd_stb),
        .rd_data(rd_data), .irq(irq), .tx_hold(tx_hold)
    );

    function automatic logic [7:0] observe(int sig);
        case (sig)
            0:       return rd_data;
            1:       return {7'd0, irq};
            default: return {7'd0, tx_hold};
        endcase
    endfunction

    task automatic compare(int sig, logic [7:0] exp, string req);
        logic [7:0] got;
        got = observe(sig);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s sig%0d: got %h expected %h at %0t", req, sig, got, exp, $time);
        end
    endtask

    // Monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            compare(e.sig, e.val, e.req);
        end
    end

    task automatic push(int sig, logic [7:0] val, string req);
        exp_t e;
        e.sig = sig; e.val = val; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    // Read strobe: the value in the strobe cycle is checked directly
    task automatic cpu_read(logic [7:0] pre, string req);
        rd_stb = 1'b1;
        #1 compare(0, pre, req);
        @(posedge clk);
        @(negedge clk);
        #1 rd_stb = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        irq_en = 1'b1;
        edges(3);
        settle();
        rst_n = 1'b1;
        settle();
        push(0, 8'h00, "R12 reset rd_data"); push(1, 0, "R12 reset irq"); push(2, 0, "R12 reset hold");
        settle();

        // R1/R3: carrier goes active
        cd_n = 1'b0;
        edges(2); push(0, 8'h00, "R1 not before third edge"); settle();
        edges(1); push(0, 8'h88, "R1 R3 carrier active"); push(1, 1, "R8 irq on flag"); settle();
        cpu_read(8'h88, "R6 pre-clear data");
        push(0, 8'h80, "R6 flags cleared"); push(1, 0, "R8 irq drops"); settle();
        cd_n = 1'b1;
        edges(3); push(0, 8'h08, "R3 carrier other direction"); settle();
        cpu_read(8'h08, "R6 read");

        // R4: ring
        ri_n = 1'b0;
        edges(3); push(0, 8'h40, "R4 no flag on level rise"); settle();
        ri_n = 1'b1;
        edges(3); push(0, 8'h04, "R4 flag on pin rise"); settle();
        cpu_read(8'h04, "R6 read");

        // R5: DSR and CTS
        dsr_n = 1'b0;
        edges(3); push(0, 8'h22, "R5 dsr flag"); settle();
        cpu_read(8'h22, "R6 read");
        cts_n = 1'b0;
        edges(3); push(0, 8'h31, "R5 cts flag"); settle();
        cpu_read(8'h31, "R6 read");

        // R8: interrupt masked
        irq_en = 1'b0;
        dsr_n = 1'b1;
        edges(3); push(0, 8'h12, "R5 dsr drop"); push(1, 0, "R8 masked irq"); settle();
        irq_en = 1'b1;
        settle(); push(1, 1, "R8 unmasked irq"); settle();
        cpu_read(8'h12, "R6 read");

        // R7: change lands on the read edge
        cts_n = 1'b1;
        edges(2);
        settle();
        cpu_read(8'h10, "R7 pre-clear data");
        push(0, 8'h01, "R7 flag survives read"); settle();
        cpu_read(8'h01, "R6 read");

        // R10/R11: flow control
        flow_en = 1'b1;
        edges(1); push(2, 1, "R11 hold when cts inactive"); settle();
        tx_busy = 1'b1; cts_n = 1'b0;
        edges(5); push(2, 1, "R11 hold kept while busy"); settle();
        tx_busy = 1'b0;
        edges(1); push(2, 0, "R11 release between chars"); settle();
        tx_busy = 1'b1; cts_n = 1'b1;
        edges(5); push(2, 0, "R11 char not cut short"); settle();
        tx_busy = 1'b0;
        edges(1); push(2, 1, "R11 hold after char"); settle();
        flow_en = 1'b0;
        edges(1); push(2, 0, "R10 disabled"); settle();
        cpu_read(8'h01, "R6 read");

        // R2/R9: loopback
        loopback = 1'b1;
        cd_n = 1'b0; ri_n = 1'b0; dsr_n = 1'b0; cts_n = 1'b0;
        edges(4); push(0, 8'h00, "R2 pins ignored"); push(1, 0, "R2 no irq"); settle();
        op2 = 1'b1; dtr = 1'b1;
        edges(1); push(0, 8'hAA, "R2 R9 looped levels"); settle();
        cpu_read(8'hAA, "R6 read");
        op1 = 1'b1;
        edges(1); push(0, 8'hE0, "R9 R4 ring rise no flag"); settle();
        op1 = 1'b0;
        edges(1); push(0, 8'hA4, "R9 R4 ring fall flag"); settle();
        cpu_read(8'hA4, "R6 read");
        rts = 1'b1;
        edges(1); push(0, 8'hB1, "R9 rts loop"); settle();
        cpu_read(8'hB1, "R6 read");

        // R1: back to pins (all active)
        loopback = 1'b0;
        edges(1); push(0, 8'hF0, "R1 pins after loopback"); settle();

        settle();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule